// File: doc/BRIEF.md
# Edge-Event Interrupt Gatherer

This block merges a small set of edge-type event lines into one level interrupt request. Each event line is synchronised into the local clock domain and rising-edge detected. A rising edge on an enabled source latches a status bit. The interrupt request stays high while any latched status bit remains set.

The block has one byte-wide register on a plain single-cycle read/write bus. The register is decoded at byte address 0x1E. A write to it loads the per-source enable mask. A read from it returns the latched status, limited to the sources that a build-time valid mask allows.

There is no separate clear action. A handler acknowledges sources by writing a mask with those sources removed, which drops their status. It then writes the full mask again to re-arm them. The bus has no back-pressure: the block takes every access in the cycle it is presented, and no data stream crosses its edge, so there is no valid/ready pair.

Top module: `evt_irq_gather`

## Requirements
- R1: After reset the enable mask and all status bits are zero, `irq_out` is low and `bus_rdata` is zero.
- R2: A write (`bus_sel`=1, `bus_wr`=1) to address 0x1E loads the enable mask from `bus_wdata`, with bit i enabling source i. A write to any other address changes nothing.
- R3: A read (`bus_sel`=1, `bus_wr`=0) at 0x1E places the status on `bus_rdata` at the next clock edge, bit i being source i. In every other cycle `bus_rdata` is zero.
- R4: A rising edge on `evt_in[i]` while source i is enabled sets status bit i three clock edges after the input changes: two synchroniser stages, then the latch. A level held high sets the bit only once.
- R5: Positions outside `VALID_MASK` can never be enabled, never latch, always read 0 and never raise the interrupt. The default is 0x3F, so bits 7 and 6 are invalid.
- R6: `irq_out` is registered. It is high on the edge after any status bit is set, and low on the edge after all status bits are clear.
- R7: A write that clears enable bit i clears status bit i on the same edge that loads the mask.
- R8: Writing 0 disables every source and clears all status.
- R9: Edges that arrive while a source is disabled are not held. After the source is enabled again, only new edges set its status.
- R10: If an edge on source i would set its status in the same cycle as a write that disables source i, the disable wins and the status stays clear.
- R11: A status bit is sticky. It stays set after its input falls, until its source is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_SRC | Asynchronous event lines, active on rising edge |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data (enable mask) |
| bus_rdata | output | 8 | Registered read data (status) |
| irq_out | output | 1 | Level interrupt request |

## Verification
A wrong enable or status bit shows up on `bus_rdata` on the edge after a read. It shows up on `irq_out` one edge after the status changes, so every fault in the latch is visible at the ports within two cycles of the access or edge that causes it. The bench keeps an independent per-cycle model and compares both outputs on every clock. This catches faults in the synchroniser depth or the edge detector, which appear as a status bit set one cycle early or late. It also catches a missed disable-wins case, which appears as a stray status bit after an acknowledge.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              wr_hit;
    logic              rd_hit;
    logic [DATA_W-1:0] wdata;
  } bus_req_t;
endpackage

// File: rtl/evt_edge_detect.sv
`timescale 1ns/1ps
module evt_edge_detect #(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raw_in,
  output logic [NUM_SRC-1:0] rise_pulse
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        last_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[TOP-1:0], raw_in[g]};
        last_q  <= chain_q[TOP];
      end
    end

    assign rise_pulse[g] = chain_q[TOP] & ~last_q;

    // R4: a detected edge lasts exactly one cycle
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse[g] |=> !rise_pulse[g]);
  end
endmodule

// File: rtl/evt_bus_decode.sv
`timescale 1ns/1ps
module evt_bus_decode
  import evt_irq_pkg::*;
#(
  parameter int               NUM_SRC    = 8,
  parameter int               ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 5'h1E,
  parameter logic [NUM_SRC-1:0] VALID_MASK = 8'h3F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_SRC-1:0] status_i,
  output bus_req_t           req_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic hit;
  logic [DATA_W-1:0] rdata_q;

  assign hit          = bus_sel && (bus_addr == REG_ADDR);
  assign req_o.wr_hit = hit && bus_wr;
  assign req_o.rd_hit = hit && !bus_wr;
  assign req_o.wdata  = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rdata_q <= '0;
    else if (req_o.rd_hit) rdata_q <= DATA_W'(status_i & VALID_MASK);
    else                   rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  // R3: read data returns to zero when no read hit the register
  assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o.rd_hit |=> rdata_o == '0);
endmodule

// File: rtl/evt_status_core.sv
`timescale 1ns/1ps
module evt_status_core
  import evt_irq_pkg::*;
#(
  parameter int                 NUM_SRC    = 8,
  parameter logic [NUM_SRC-1:0] VALID_MASK = 8'h3F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bus_req_t           req_i,
  input  logic [NUM_SRC-1:0] rise_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] st_q, st_d;
  logic               irq_q;

  always_comb begin
    en_d = en_q;
    if (req_i.wr_hit) en_d = req_i.wdata[NUM_SRC-1:0] & VALID_MASK;
    // disable on this write wins over a same-cycle edge
    st_d = en_d & (st_q | (rise_i & en_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      st_q  <= st_d;
      irq_q <= |st_q;
    end
  end

  assign status_o = st_q;
  assign irq_o    = irq_q;

  // R7 and R10: after a write, no status bit outside the written mask survives
  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_i.wr_hit |=> (st_q & ~$past(req_i.wdata[NUM_SRC-1:0])) == '0);

  // R8: a zero write empties the status
  assert_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i.wr_hit && req_i.wdata[NUM_SRC-1:0] == '0) |=> st_q == '0);

  // R9: with everything disabled and no write, nothing latches
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && !req_i.wr_hit) |=> st_q == '0);

  // R11: status only falls on a write
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i.wr_hit |=> (($past(st_q) & ~st_q) == '0));
endmodule

// File: rtl/evt_irq_gather.sv
`timescale 1ns/1ps
module evt_irq_gather
  import evt_irq_pkg::*;
#(
  parameter int                 NUM_SRC     = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 ADDR_W      = 5,
  parameter logic [ADDR_W-1:0]  REG_ADDR    = 5'h1E,
  parameter logic [NUM_SRC-1:0] VALID_MASK  = 8'h3F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               irq_out
);
  bus_req_t           req;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] status;

  evt_edge_detect #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .raw_in(evt_in), .rise_pulse(rise));

  evt_bus_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
                   .VALID_MASK(VALID_MASK)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_i(status),
    .req_o(req), .rdata_o(bus_rdata));

  evt_status_core #(.NUM_SRC(NUM_SRC), .VALID_MASK(VALID_MASK)) u_core (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rise_i(rise),
    .status_o(status), .irq_o(irq_out));

  // R5: invalid positions never appear on the read bus
  assert_invalid_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~8'(VALID_MASK)) == '0);

  // R6: latched status raises the request one edge later
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0) |=> irq_out);

  // R6: empty status drops the request one edge later
  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> !irq_out);
endmodule

// File: tb/evt_irq_gather_tb.sv
`timescale 1ns/1ps
module evt_irq_gather_tb_top;
  localparam logic [7:0] VALID = 8'h3F;
  localparam logic [4:0] RADDR = 5'h1E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_in = '0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_out;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  evt_irq_gather dut_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  // behavioural reference
  logic [7:0] m_en = '0, m_st = '0, m_rd = '0;
  logic       m_irq = 1'b0;
  logic [7:0] hist[$] = '{8'h00, 8'h00, 8'h00};

  always @(posedge clk) begin
    logic [7:0] edge_v, en_new;
    bit wr_hit, rd_hit;
    if (!rst_n) begin
      m_en = '0; m_st = '0; m_rd = '0; m_irq = 1'b0;
      hist = '{8'h00, 8'h00, 8'h00};
    end else begin
      edge_v = hist[1] & ~hist[2];
      wr_hit = bus_sel && bus_wr && bus_addr == RADDR;
      rd_hit = bus_sel && !bus_wr && bus_addr == RADDR;
      m_irq  = (m_st != 0);
      m_rd   = rd_hit ? (m_st & VALID) : 8'h00;
      en_new = wr_hit ? (bus_wdata & VALID) : m_en;
      m_st   = en_new & (m_st | (edge_v & m_en));
      m_en   = en_new;
      hist.push_front(evt_in);
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h expected=%02h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check({cur_tag, " irq model"}, {7'd0, irq_out}, {7'd0, m_irq});
    check({cur_tag, " rdata model"}, bus_rdata, m_rd);
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic reg_write(logic [4:0] a, logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic reg_read(logic [4:0] a, string tag, logic [7:0] exp);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    tick();
    bus_sel = 0;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got=0 expected=1");
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    cur_tag = "R1";
    check("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    reg_read(RADDR, "R1 status after reset", 8'h00);

    // enable all, invalid bits filtered
    cur_tag = "R2 R5";
    reg_write(RADDR, 8'hFF);
    evt_in = 8'hFF;
    tick(3);
    check("R4 irq not yet high", {7'd0, irq_out}, 8'h00);
    tick();
    check("R6 irq high after status", {7'd0, irq_out}, 8'h01);
    reg_read(RADDR, "R5 valid bits only", 8'h3F);

    cur_tag = "R11";
    evt_in = 8'h00;
    tick(4);
    reg_read(RADDR, "R11 sticky after fall", 8'h3F);

    cur_tag = "R7";
    reg_write(RADDR, 8'h3E);
    reg_read(RADDR, "R7 ack clears bit0", 8'h3E);

    cur_tag = "R8";
    reg_write(RADDR, 8'h00);
    reg_read(RADDR, "R8 zero write clears", 8'h00);
    tick();
    check("R6 irq low after clear", {7'd0, irq_out}, 8'h00);

    cur_tag = "R9";
    evt_in = 8'h02; tick(4); evt_in = 8'h00; tick(4);
    reg_write(RADDR, 8'h02);
    reg_read(RADDR, "R9 disabled edge not held", 8'h00);
    evt_in = 8'h02; tick(4);
    reg_read(RADDR, "R9 new edge latches", 8'h02);
    evt_in = 8'h00;
    reg_write(RADDR, 8'h00);

    cur_tag = "R10";
    reg_write(RADDR, 8'h04);
    tick(2);
    evt_in = 8'h04;
    tick(2);
    reg_write(RADDR, 8'h00);
    reg_write(RADDR, 8'h04);
    tick(3);
    reg_read(RADDR, "R10 disable wins", 8'h00);
    evt_in = 8'h00;
    reg_write(RADDR, 8'h00);

    cur_tag = "R2 R3";
    reg_write(RADDR, 8'h01);
    reg_write(5'h1D, 8'h00);
    evt_in = 8'h01; tick(4);
    reg_read(RADDR, "R2 other address write ignored", 8'h01);
    reg_read(5'h1D, "R3 other address reads zero", 8'h00);
    check("R3 idle rdata zero", bus_rdata, 8'h00);
    evt_in = 8'h00;
    reg_write(RADDR, 8'h00);

    cur_tag = "R5";
    reg_write(RADDR, 8'hC0);
    evt_in = 8'hC0; tick(5);
    check("R5 invalid no irq", {7'd0, irq_out}, 8'h00);
    reg_read(RADDR, "R5 invalid no status", 8'h00);
    evt_in = 8'h00;
    tick(3);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule